// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This block is a SIMD arithmetic unit that, for every 32-bit lane of a packed vector, forms the dot product of four byte pairs drawn from two source vectors and adds it to the matching lane of an accumulator vector. Each lane owns four adjacent bytes of each source. A two-bit mode chooses how the bytes are extended before multiplying: both signed, first source signed with the second unsigned, or both unsigned. A second control picks between modulo-2^32 accumulation and clamping to the 32-bit range that fits the mode.

The vector width is a parameter (128 or 256 bits, giving 4 or 8 lanes). The result port is a fixed, wider bus, and every bit above the configured width reads as zero. A valid strobe launches an operation, and the packed result appears in a register one cycle later together with an output valid flag. A parameter can remove that register for a purely combinational variant.

Top module: `dpacc_top`

## Requirements
- R1: Output lane j (bits 32j+31..32j, j from 0 to VEC_W/32-1) depends only on accumulator bits 32j+31..32j and on source bytes 4j, 4j+1, 4j+2 and 4j+3 of both sources (byte k is bits 8k+7..8k), each byte of the first source paired with the byte at the same index of the second.
- R2: Mode encoding: 2'b00 extends both bytes as signed, 2'b01 extends the first source as signed and the second as unsigned, 2'b10 extends both as unsigned. Every product is exact, e.g. 255*255 = 65025 in mode 2'b10 and -128*255 = -32640 in mode 2'b01.
- R3: With sat_en = 0, each output lane equals the accumulator lane plus the four products, modulo 2^32, in every mode.
- R4: With sat_en = 1 in modes 2'b00 and 2'b01, the accumulator lane is read as two's complement and the exact sum is clamped to the range 0x80000000..0x7FFFFFFF.
- R5: With sat_en = 1 in mode 2'b10, the accumulator lane is read as unsigned and the exact sum is clamped to 0..0xFFFFFFFF, so the result never falls below the accumulator.
- R6: Output bits from VEC_W up to MAX_W-1 are always zero.
- R7: A synchronous active-high reset clears out_valid and the result register to zero; after in_valid is high at a rising edge, out_valid is high and out_res holds that operation's result after that edge.
- R8: While in_valid is low at a rising edge, out_valid goes low after that edge and out_res keeps its previous value, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Launches an operation on the current inputs |
| mode | input | 2 | Operand signedness select (R2 encoding) |
| sat_en | input | 1 | 1 selects clamping, 0 selects wrap-around |
| acc_w | input | VEC_W | Packed 32-bit accumulator lanes |
| src_a | input | VEC_W | First packed byte source |
| src_b | input | VEC_W | Second packed byte source |
| out_valid | output | 1 | Result register holds a fresh result |
| out_res | output | MAX_W | Packed 32-bit results, zero above VEC_W |

## Verification
The assertions take for granted that mode never carries the unused code 2'b11 while in_valid is high, and one of them checks that assumption directly; the stimulus draws the mode only from the three legal codes. The clamp assertions presume the accumulator and sources of a launched operation are the values present at that edge, so the bench changes inputs only at falling edges. Random accumulator lanes are steered toward the signed and unsigned extremes often enough that both clamp directions and the plain wrap are reached, alongside directed cases at the exact range limits.

// File: rtl/dpacc_pkg.sv
`timescale 1ns/1ps
package dpacc_pkg;

  localparam int BYTE_W  = 8;
  localparam int LANE_W  = 32;
  localparam int BPL     = LANE_W / BYTE_W;   // bytes per lane
  localparam int EXT_W   = BYTE_W + 1;        // byte with room for a sign
  localparam int PROD_W  = 2 * EXT_W;         // exact product width
  localparam int PSUM_W  = PROD_W + 2;        // four products
  localparam int FULL_W  = LANE_W + 3;        // exact lane sum

  typedef enum logic [1:0] {
    DP_SS = 2'b00,
    DP_SU = 2'b01,
    DP_UU = 2'b10
  } dp_mode_e;

  typedef logic signed [EXT_W-1:0]  ext_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [FULL_W-1:0] full_t;

  localparam full_t S_MAX = full_t'({3'b000, 1'b0, {(LANE_W-1){1'b1}}});
  localparam full_t S_MIN = full_t'({3'b111, 1'b1, {(LANE_W-1){1'b0}}});
  localparam full_t U_MAX = full_t'({3'b000, {LANE_W{1'b1}}});

  // Widen one byte, as signed or as unsigned.
  function automatic ext_t widen_byte(input logic [BYTE_W-1:0] v, input logic sgn);
    return ext_t'({sgn & v[BYTE_W-1], v});
  endfunction

  // Exact signed product of two widened bytes.
  function automatic prod_t byte_prod(input ext_t x, input ext_t y);
    return prod_t'(x * y);
  endfunction

  // Bring a product up to the full sum width.
  function automatic full_t prod_to_full(input prod_t p);
    return full_t'({{(FULL_W-PROD_W){p[PROD_W-1]}}, p});
  endfunction

  // Bring an accumulator lane up to the full sum width.
  function automatic full_t acc_to_full(input logic [LANE_W-1:0] w, input logic as_unsigned);
    logic top;
    top = as_unsigned ? 1'b0 : w[LANE_W-1];
    return full_t'({{(FULL_W-LANE_W){top}}, w});
  endfunction

  function automatic logic above_limit(input full_t s, input logic as_unsigned);
    return as_unsigned ? (s > U_MAX) : (s > S_MAX);
  endfunction

  function automatic logic below_limit(input full_t s, input logic as_unsigned);
    return as_unsigned ? (s < full_t'(0)) : (s < S_MIN);
  endfunction

  function automatic logic [LANE_W-1:0] top_value(input logic as_unsigned);
    return as_unsigned ? {LANE_W{1'b1}} : {1'b0, {(LANE_W-1){1'b1}}};
  endfunction

  function automatic logic [LANE_W-1:0] bottom_value(input logic as_unsigned);
    return as_unsigned ? {LANE_W{1'b0}} : {1'b1, {(LANE_W-1){1'b0}}};
  endfunction

endpackage

// File: rtl/dpacc_byte_mul.sv
`timescale 1ns/1ps
module dpacc_byte_mul
  import dpacc_pkg::*;
(
  input  logic [BYTE_W-1:0] a_byte,
  input  logic [BYTE_W-1:0] b_byte,
  input  logic              a_signed,
  input  logic              b_signed,
  output prod_t             prod
);

  ext_t a_ext;
  ext_t b_ext;

  always_comb begin
    a_ext = widen_byte(a_byte, a_signed);
    b_ext = widen_byte(b_byte, b_signed);
    prod  = byte_prod(a_ext, b_ext);
  end

endmodule

// File: rtl/dpacc_lane.sv
`timescale 1ns/1ps
module dpacc_lane
  import dpacc_pkg::*;
(
  input  logic [LANE_W-1:0] acc,
  input  logic [LANE_W-1:0] a_lane,
  input  logic [LANE_W-1:0] b_lane,
  input  logic [1:0]        mode,
  input  logic              sat_en,
  output logic [LANE_W-1:0] res,
  output logic              clip_hi,
  output logic              clip_lo
);

  logic  a_sgn;
  logic  b_sgn;
  logic  uns_acc;
  prod_t prods [BPL];
  full_t prod_sum;
  full_t full_sum;

  // Operand signedness from the mode code
  always_comb begin
    a_sgn   = (mode != DP_UU);
    b_sgn   = (mode == DP_SS);
    uns_acc = (mode == DP_UU);
  end

  for (genvar k = 0; k < BPL; k++) begin : g_mul
    dpacc_byte_mul u_mul (
      .a_byte   (a_lane[k*BYTE_W +: BYTE_W]),
      .b_byte   (b_lane[k*BYTE_W +: BYTE_W]),
      .a_signed (a_sgn),
      .b_signed (b_sgn),
      .prod     (prods[k])
    );
  end

  // Exact sum at full width, then choose wrap or clamp
  always_comb begin
    prod_sum = '0;
    for (int k = 0; k < BPL; k++) begin
      prod_sum = prod_sum + prod_to_full(prods[k]);
    end
    full_sum = acc_to_full(acc, uns_acc) + prod_sum;
    clip_hi  = sat_en & above_limit(full_sum, uns_acc);
    clip_lo  = sat_en & below_limit(full_sum, uns_acc);
    if (clip_hi) begin
      res = top_value(uns_acc);
    end else if (clip_lo) begin
      res = bottom_value(uns_acc);
    end else begin
      res = full_sum[LANE_W-1:0];
    end
  end

endmodule

// File: rtl/dpacc_top.sv
`timescale 1ns/1ps
module dpacc_top
  import dpacc_pkg::*;
#(
  parameter int VEC_W   = 256,
  parameter int MAX_W   = 512,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic             sat_en,
  input  logic [VEC_W-1:0] acc_w,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic             out_valid,
  output logic [MAX_W-1:0] out_res
);

  localparam int LANES = VEC_W / LANE_W;
  localparam int PAD_W = MAX_W - VEC_W;

  logic [VEC_W-1:0] res_comb;
  logic [VEC_W-1:0] res_q;
  logic [LANES-1:0] lane_clip_hi;
  logic [LANES-1:0] lane_clip_lo;

  initial begin
    if ((VEC_W != 128 && VEC_W != 256) || MAX_W < VEC_W) begin
      $error("dpacc_top: unsupported width parameters");
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    dpacc_lane u_lane (
      .acc     (acc_w[j*LANE_W +: LANE_W]),
      .a_lane  (src_a[j*LANE_W +: LANE_W]),
      .b_lane  (src_b[j*LANE_W +: LANE_W]),
      .mode    (mode),
      .sat_en  (sat_en),
      .res     (res_comb[j*LANE_W +: LANE_W]),
      .clip_hi (lane_clip_hi[j]),
      .clip_lo (lane_clip_lo[j])
    );
  end

  if (OUT_REG) begin : g_reg
    logic valid_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= 1'b0;
        res_q   <= '0;
      end else begin
        valid_q <= in_valid;
        if (in_valid) begin
          res_q <= res_comb;
        end
      end
    end

    assign out_valid = valid_q;

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> (mode != 2'b11)); // R2

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R7

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R8

    AST_RES_HELD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_res)); // R8

    AST_NO_BOTH_CLIPS: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ((lane_clip_hi & lane_clip_lo) == '0)); // R4

    for (genvar j = 0; j < LANES; j++) begin : g_chk
      AST_UNSIGNED_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_en && mode == DP_UU)
        |=> (out_res[j*LANE_W +: LANE_W] >= $past(acc_w[j*LANE_W +: LANE_W]))); // R5

      AST_UNSIGNED_PINNED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_en && mode == DP_UU && acc_w[j*LANE_W +: LANE_W] == '1)
        |=> (out_res[j*LANE_W +: LANE_W] == '1)); // R5

      AST_SIGNED_PINNED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_en && mode == DP_SS
         && acc_w[j*LANE_W +: LANE_W] == {1'b0, {(LANE_W-1){1'b1}}}
         && src_a[j*LANE_W +: LANE_W] == src_b[j*LANE_W +: LANE_W])
        |=> (out_res[j*LANE_W +: LANE_W] == {1'b0, {(LANE_W-1){1'b1}}})); // R4
    end
  end else begin : g_comb
    assign res_q     = res_comb;
    assign out_valid = in_valid;
  end

  if (PAD_W > 0) begin : g_pad
    assign out_res = {{PAD_W{1'b0}}, res_q};
  end else begin : g_nopad
    assign out_res = res_q;
  end

endmodule

// File: tb/dpacc_top_tb_top.sv
`timescale 1ns/1ps
module dpacc_top_tb_top;

  localparam int VEC_W = 256;
  localparam int MAX_W = 512;
  localparam int LANES = VEC_W / 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [1:0]       mode = 2'b00;
  logic             sat_en = 1'b0;
  logic [VEC_W-1:0] acc_w = '0;
  logic [VEC_W-1:0] src_a = '0;
  logic [VEC_W-1:0] src_b = '0;
  logic             out_valid;
  logic [MAX_W-1:0] out_res;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dpacc_top #(.VEC_W(VEC_W), .MAX_W(MAX_W), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .sat_en(sat_en),
    .acc_w(acc_w), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_res(out_res)
  );

  // Reference for one lane, in plain integer arithmetic.
  function automatic logic [31:0] ref_lane(logic [31:0] w, logic [31:0] a,
                                           logic [31:0] b, logic [1:0] m, bit s);
    longint total_v;
    longint x;
    longint y;
    if (m == 2'b10) total_v = longint'(w);
    else            total_v = longint'($signed(w));
    for (int k = 0; k < 4; k++) begin
      x = longint'(a[8*k +: 8]);
      y = longint'(b[8*k +: 8]);
      if (m != 2'b10 && x > 127) x = x - 256;
      if (m == 2'b00 && y > 127) y = y - 256;
      total_v = total_v + x * y;
    end
    if (s) begin
      if (m == 2'b10) begin
        if (total_v > 64'sd4294967295) total_v = 64'sd4294967295;
        if (total_v < 0) total_v = 0;
      end else begin
        if (total_v > 64'sd2147483647) total_v = 64'sd2147483647;
        if (total_v < -64'sd2147483648) total_v = -64'sd2147483648;
      end
    end
    return total_v[31:0];
  endfunction

  function automatic logic [MAX_W-1:0] ref_vec(logic [VEC_W-1:0] w, logic [VEC_W-1:0] a,
                                               logic [VEC_W-1:0] b, logic [1:0] m, bit s);
    logic [MAX_W-1:0] v;
    v = '0;
    for (int j = 0; j < LANES; j++) begin
      v[32*j +: 32] = ref_lane(w[32*j +: 32], a[32*j +: 32], b[32*j +: 32], m, s);
    end
    return v;
  endfunction

  task automatic chk(string tag, logic [MAX_W-1:0] act, logic [MAX_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Launch one operation at a falling edge, check it one edge later.
  task automatic run_op(string tag, logic [1:0] m, bit s, logic [VEC_W-1:0] w,
                        logic [VEC_W-1:0] a, logic [VEC_W-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; mode = m; sat_en = s; acc_w = w; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid (R7)"}, MAX_W'(out_valid), MAX_W'(1));
    chk(tag, out_res, ref_vec(w, a, b, m, s));
  endtask

  function automatic logic [31:0] edge_word(int sel);
    case (sel)
      0: return 32'h7FFF_FF00 | ($urandom() & 32'hFF);
      1: return 32'h8000_0000 | ($urandom() & 32'hFF);
      2: return 32'hFFFF_FF00 | ($urandom() & 32'hFF);
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired (R7) actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [VEC_W-1:0] w;
    logic [VEC_W-1:0] a;
    logic [VEC_W-1:0] b;
    logic [MAX_W-1:0] held;
    void'($urandom(32'd20240611));

    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7 reset valid", MAX_W'(out_valid), '0);
    chk("R7 reset result", out_res, '0);
    rst = 1'b0;

    // R2, R3: unsigned extremes, exact 255*255
    run_op("R2 uu 255x255 wrap", 2'b10, 1'b0, '0, '1, '1);
    // R2: signed -128 * -128
    run_op("R2 ss -128x-128", 2'b00, 1'b0, '0, {32{8'h80}}, {32{8'h80}});
    // R2: mixed -128 * 255
    run_op("R2 su -128x255", 2'b01, 1'b0, '0, {32{8'h80}}, '1);

    // R1: a single byte in lane 1 touches only lane 1
    w = '0;
    for (int j = 0; j < LANES; j++) w[32*j +: 32] = 32'h1000 * (j + 1);
    a = '0; a[8*5 +: 8] = 8'h03;
    run_op("R1 lane position", 2'b00, 1'b0, w, a, {32{8'h02}});

    // R3: signed wrap past the top of the range
    run_op("R3 ss wrap", 2'b00, 1'b0, {LANES{32'h7FFF_FFFF}}, {32{8'h7F}}, {32{8'h7F}});
    // R4: same sum clamped high
    run_op("R4 ss clamp high", 2'b00, 1'b1, {LANES{32'h7FFF_FFFF}}, {32{8'h7F}}, {32{8'h7F}});
    // R4: mixed mode clamped low
    run_op("R4 su clamp low", 2'b01, 1'b1, {LANES{32'h8000_0000}}, {32{8'h80}}, '1);
    // R4: signed read of 0x80000000, small positive sum, no clamp
    run_op("R4 ss no clamp", 2'b00, 1'b1, {LANES{32'h8000_0000}}, {32{8'h01}}, {32{8'h01}});
    // R5: unsigned clamp at all-ones
    run_op("R5 uu clamp", 2'b10, 1'b1, {LANES{32'hFFFF_FF00}}, '1, '1);
    // R5: 0x80000000 read unsigned, no clamp
    run_op("R5 uu large acc", 2'b10, 1'b1, {LANES{32'h8000_0000}}, {32{8'h01}}, {32{8'h01}});
    // R3: unsigned wrap without clamp
    run_op("R3 uu wrap", 2'b10, 1'b0, {LANES{32'hFFFF_FF00}}, '1, '1);

    // R8: idle cycle with changing data keeps the result
    held = out_res;
    @(negedge clk);
    in_valid = 1'b0; acc_w = '1; src_a = '1; src_b = {32{8'h80}}; mode = 2'b10; sat_en = 1'b0;
    @(negedge clk);
    chk("R8 idle valid", MAX_W'(out_valid), '0);
    chk("R8 idle hold", out_res, held);

    // Random mix of all modes and both accumulation kinds
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      bit s;
      m = 2'($urandom_range(0, 2));
      s = 1'($urandom());
      for (int j = 0; j < LANES; j++) begin
        w[32*j +: 32] = edge_word(int'($urandom_range(0, 5)));
        a[32*j +: 32] = $urandom();
        b[32*j +: 32] = $urandom();
      end
      run_op(s ? "R4 R5 random sat" : "R3 random wrap", m, s, w, a, b);
      // R6: bits above the vector width
      chk("R6 upper zero", MAX_W'(out_res[MAX_W-1:VEC_W]), '0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule